// File: doc/BRIEF.md
# Bit-Serial Two's Complement Adder-Subtractor

This block adds or subtracts two two's complement words one bit position per clock. Both operands enter on single-bit inputs with the least significant bit first. The result leaves on a single-bit output in the same order, in the same cycle as the operand bits that produce it. A single full-adder cell does the arithmetic. One carry flip-flop carries the carry from one bit slot to the next, so a word of N bits takes N clocks.

A start strobe marks bit 0 of a word and a last strobe marks bit N-1. The operation select is sampled on the start cycle and held for the rest of the word. Subtraction inverts each B bit and loads the carry flip-flop with a 1 at the start, which adds one to the inverted operand. On the last bit the block checks whether the operand and result signs agree and registers an overflow flag. It also pulses a word-complete flag for one cycle. The carry out of the most significant bit is dropped.

Top module: `serial_addsub`

## Requirements
- R1: When `rst` is high at a rising edge, `done_o`, `ovf_o`, the carry flip-flop and the held operation are all cleared at that edge.
- R2: With `op_i` = 0 sampled at the start cycle, the bits on `sum_o`, read least significant first, form (A + B) mod 2^N.
- R3: With `op_i` = 1 sampled at the start cycle, the bits on `sum_o` form (A - B) mod 2^N. Each B bit is inverted and the carry-in of bit 0 is 1.
- R4: On a start cycle the carry-in of the adder equals `op_i`, whatever carry the previous word or an idle cycle left behind. The carry out of bit N-1 has no effect on any later word.
- R5: `op_i` is read only on the start cycle. Changes on `op_i` during bits 1 to N-1 do not change the result of that word.
- R6: At the rising edge that ends a last-bit cycle, `ovf_o` is loaded with 1 exactly when A and the effective B (after inversion) have the same sign bit and the result sign bit differs. For the bench this means the signed result lies outside [-2^(N-1), 2^(N-1)-1]. At all other edges `ovf_o` holds its value.
- R7: `done_o` is 1 for exactly the one cycle that follows a last-bit cycle, and 0 in every other cycle.
- R8: The last strobe is applied exactly WORD_W-1 cycles after the start strobe, with no start strobe between them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Marks the cycle that carries bit 0 of a word |
| last_i | input | 1 | Marks the cycle that carries bit N-1 of a word |
| op_i | input | 1 | 0 selects add, 1 selects subtract; sampled with `start_i` |
| a_i | input | 1 | Operand A bit, least significant first |
| b_i | input | 1 | Operand B bit, least significant first |
| sum_o | output | 1 | Result bit for the operand bits of the current cycle |
| ovf_o | output | 1 | Registered signed overflow of the last completed word |
| done_o | output | 1 | One-cycle pulse after the last bit of a word |

## Verification
The assertions check on every cycle that reset clears the state, that the carry-in on a start cycle follows the select, and that the held operation changes only at a start. They also check that the overflow flag moves only after a last-bit cycle, that the done pulse follows exactly the last strobe, and that the framing strobes are spaced one word apart. Only the bench's scenarios can show that the serial bits add up to the correct arithmetic value. This covers a full sweep of every operand pair in both modes on a 4-bit word. The bench scenarios also show that overflow matches the signed range, that a mid-word change of the select is ignored, and that a carry left in the flip-flop does not leak into the next word.

// File: rtl/serial_addsub_pkg.sv
package serial_addsub_pkg;

   typedef enum logic {
      OP_ADD = 1'b0,
      OP_SUB = 1'b1
   } sas_op_e;

   // adder cell implementation variants
   localparam int SAS_FA_GATE  = 0;
   localparam int SAS_FA_HALVES = 1;

endpackage

// File: rtl/sas_full_adder.sv
module sas_full_adder #(
   parameter int STYLE = 0
) (
   input  logic x_i,
   input  logic y_i,
   input  logic ci_i,
   output logic s_o,
   output logic co_o
);
   import serial_addsub_pkg::*;

   generate
      if (STYLE == SAS_FA_GATE) begin : g_gate
         assign s_o  = x_i ^ y_i ^ ci_i;
         assign co_o = (x_i & y_i) | (x_i & ci_i) | (y_i & ci_i);
      end else if (STYLE == SAS_FA_HALVES) begin : g_halves
         logic p, g, g2;
         assign p    = x_i ^ y_i;
         assign g    = x_i & y_i;
         assign s_o  = p ^ ci_i;
         assign g2   = p & ci_i;
         assign co_o = g | g2;
      end else begin : g_bad
         $error("sas_full_adder: unsupported STYLE %0d", STYLE);
      end
   endgenerate

endmodule

// File: rtl/sas_operand_mux.sv
module sas_operand_mux (
   input  logic b_i,
   input  logic inv_i,
   output logic b_eff_o
);
   // 2:1 selection between the true and complemented operand bit
   always_comb begin
      if (inv_i) b_eff_o = ~b_i;
      else       b_eff_o = b_i;
   end
endmodule

// File: rtl/sas_carry_reg.sv
module sas_carry_reg (
   input  logic clk,
   input  logic rst,
   input  logic prime_i,
   input  logic prime_val_i,
   input  logic co_i,
   output logic ci_o
);
   logic carry_q;

   always_ff @(posedge clk) begin
      if (rst) carry_q <= 1'b0;
      else     carry_q <= co_i;
   end

   // on a start cycle the stored carry is replaced by the priming value
   assign ci_o = prime_i ? prime_val_i : carry_q;

   // R1
   carry_reset_chk: assert property (@(posedge clk) rst |=> !carry_q);

endmodule

// File: rtl/serial_addsub.sv
module serial_addsub #(
   parameter int WORD_W   = 8,
   parameter int FA_STYLE = 0
) (
   input  logic clk,
   input  logic rst,
   input  logic start_i,
   input  logic last_i,
   input  logic op_i,
   input  logic a_i,
   input  logic b_i,
   output logic sum_o,
   output logic ovf_o,
   output logic done_o
);
   import serial_addsub_pkg::*;

   localparam int IDX_W = (WORD_W > 2) ? $clog2(WORD_W) : 1;
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORD_W - 1);

   generate
      if (WORD_W < 2) begin : g_chk_w
         $error("serial_addsub: WORD_W must be at least 2, got %0d", WORD_W);
      end
   endgenerate

   sas_op_e    op_q;
   sas_op_e    op_eff;
   logic       b_eff;
   logic       cin;
   logic       cout;
   logic       s_bit;
   logic       ovf_q;
   logic       done_q;
   logic [IDX_W-1:0] idx_q;

   // operation held for the word, taken live on the start cycle
   assign op_eff = start_i ? sas_op_e'(op_i) : op_q;

   always_ff @(posedge clk) begin
      if (rst)          op_q <= OP_ADD;
      else if (start_i) op_q <= sas_op_e'(op_i);
   end

   sas_operand_mux u_bmux (
      .b_i     (b_i),
      .inv_i   (op_eff == OP_SUB),
      .b_eff_o (b_eff)
   );

   sas_carry_reg u_carry (
      .clk         (clk),
      .rst         (rst),
      .prime_i     (start_i),
      .prime_val_i (op_i),
      .co_i        (cout),
      .ci_o        (cin)
   );

   sas_full_adder #(.STYLE(FA_STYLE)) u_fa (
      .x_i  (a_i),
      .y_i  (b_eff),
      .ci_i (cin),
      .s_o  (s_bit),
      .co_o (cout)
   );

   assign sum_o = s_bit;

   // sign check taken on the most significant bit slot
   always_ff @(posedge clk) begin
      if (rst) begin
         ovf_q  <= 1'b0;
         done_q <= 1'b0;
      end else begin
         done_q <= last_i;
         if (last_i) ovf_q <= (a_i == b_eff) && (s_bit != a_i);
      end
   end

   assign ovf_o  = ovf_q;
   assign done_o = done_q;

   // bit position inside the current word, used to check framing
   always_ff @(posedge clk) begin
      if (rst)          idx_q <= '0;
      else if (start_i) idx_q <= IDX_W'(1);
      else              idx_q <= idx_q + IDX_W'(1);
   end

   // R1
   state_reset_chk: assert property (@(posedge clk)
      rst |=> (!done_q && !ovf_q && op_q == OP_ADD));

   // R4
   carry_prime_chk: assert property (@(posedge clk) disable iff (rst)
      start_i |-> (cin == op_i));

   // R5
   op_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !start_i |=> $stable(op_q));

   // R6
   ovf_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !last_i |=> $stable(ovf_q));

   // R7
   done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      last_i |=> done_q);

   // R7
   done_idle_chk: assert property (@(posedge clk) disable iff (rst)
      !last_i |=> !done_q);

   // R8
   frame_len_chk: assert property (@(posedge clk) disable iff (rst)
      last_i |-> (!start_i && idx_q == LAST_IDX));

endmodule

// File: tb/serial_addsub_tb.sv
module serial_addsub_tb;

   localparam int N = 4;

   logic clk = 1'b0;
   logic rst, start_i, last_i, op_i, a_i, b_i;
   logic sum_o, ovf_o, done_o;

   int errors = 0;
   int checks = 0;
   int cyc = 0;
   logic ovf_prev = 1'b0;

   always #2.5 clk = ~clk;

   serial_addsub #(.WORD_W(N), .FA_STYLE(0)) u_dut (
      .clk(clk), .rst(rst), .start_i(start_i), .last_i(last_i),
      .op_i(op_i), .a_i(a_i), .b_i(b_i),
      .sum_o(sum_o), .ovf_o(ovf_o), .done_o(done_o)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // drives one framed word; mode toggles after bit 0 when flip is set
   task automatic run_word(input logic m, input int a, input int b, input bit flip,
                           output logic [N-1:0] got);
      for (int i = 0; i < N; i++) begin
         @(negedge clk);
         start_i = (i == 0);
         last_i  = (i == N - 1);
         op_i    = (flip && i > 0) ? ~m : m;
         a_i     = a[i];
         b_i     = b[i];
         #1;
         got[i] = sum_o;
         // R7 no pulse while a word is in flight
         chk(done_o == 1'b0, "R7 done low mid-word", int'(done_o), 0);
         // R6 flag holds until the next last bit
         chk(ovf_o == ovf_prev, "R6 ovf hold", int'(ovf_o), int'(ovf_prev));
      end
      @(negedge clk);
      start_i = 1'b0;
      last_i  = 1'b0;
      op_i    = 1'b0;
   endtask

   task automatic word_and_check(input logic m, input int a, input int b,
                                 input bit flip, input string tag);
      logic [N-1:0] got;
      int sa, sb, r;
      bit eo;
      sa = (a >= 8) ? a - 16 : a;
      sb = (b >= 8) ? b - 16 : b;
      r  = m ? sa - sb : sa + sb;
      eo = (r > 7) || (r < -8);
      run_word(m, a, b, flip, got);
      chk(got == N'(r & 15), tag, int'(got), r & 15);
      chk(done_o == 1'b1, "R7 done pulse", int'(done_o), 1);
      chk(ovf_o == eo, "R6 overflow", int'(ovf_o), int'(eo));
      ovf_prev = eo;
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cyc++;
         if (cyc > 100000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=0", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
         end
      end
   end

   initial begin
      rst = 1'b1; start_i = 1'b0; last_i = 1'b0; op_i = 1'b0; a_i = 1'b0; b_i = 1'b0;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(done_o == 1'b0, "R1 done after reset", int'(done_o), 0);
      chk(ovf_o == 1'b0, "R1 ovf after reset", int'(ovf_o), 0);
      rst = 1'b0;

      // R2 / R3 exhaustive sweep, both modes
      for (int m = 0; m < 2; m++)
         for (int a = 0; a < 16; a++)
            for (int b = 0; b < 16; b++)
               word_and_check(m[0], a, b, 1'b0, m ? "R3 difference" : "R2 sum");

      // R4 word leaving carry out 1 (15+1), then a word that must see none
      word_and_check(1'b0, 15, 1, 1'b0, "R4 carry dropped");
      word_and_check(1'b0, 0, 0, 1'b0, "R4 fresh carry after carry out");
      word_and_check(1'b1, 0, 0, 1'b0, "R4 subtract primes carry");

      // R5 select changes after the start cycle are ignored
      word_and_check(1'b1, 5, 3, 1'b1, "R5 subtract held");
      word_and_check(1'b0, 5, 3, 1'b1, "R5 add held");
      word_and_check(1'b0, 7, 1, 1'b1, "R5 add held with overflow");

      // R1 reset clears an overflow flag and a partial word
      @(negedge clk);
      start_i = 1'b1; op_i = 1'b1; a_i = 1'b1; b_i = 1'b0;
      @(negedge clk);
      start_i = 1'b0; rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      chk(ovf_o == 1'b0, "R1 ovf cleared", int'(ovf_o), 0);
      chk(done_o == 1'b0, "R1 done cleared", int'(done_o), 0);
      ovf_prev = 1'b0;
      // held op cleared to add, next word framed fresh
      word_and_check(1'b0, 2, 3, 1'b0, "R1 word after reset");

      @(negedge clk);
      // R7 pulse lasts a single cycle
      chk(done_o == 1'b0, "R7 done single cycle", int'(done_o), 0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule